// File: doc/BRIEF.md
# Cursor Sprite Overlay

This block lays a 64 by 64 pointer image with two bits per pixel over an 8-bit indexed video stream. The host fills the sprite image one byte at a time through a write port. Alongside the image it supplies two cursor colours, a hot-spot offset inside the image, the cursor position in logical-screen coordinates, and an enable. These are static inputs that host-side registers hold.

For every pixel of the stream the block receives the physical screen x and y, the current panning offsets and the background value. It works out whether that pixel lies under the sprite. If it does, it decodes the two-bit code there and emits one of three things: a cursor colour, the untouched background, or the background with every bit inverted. The result is registered, so the output follows the input by exactly one clock.

Top module: `cursor_overlay`

## Requirements
- R1: While `rstN` is low, `pixOut` is 0.
- R2: With `curEn` low, `pixOut` equals the `bgIn` of the previous cycle whatever the sprite image holds.
- R3: `pixOut` is the result for the pixel inputs sampled at the preceding rising clock edge, one cycle of latency.
- R4: A sprite code of plane0=0, plane1=0 outputs `colorTwo`.
- R5: A sprite code of plane0=0, plane1=1 outputs `colorOne`.
- R6: A sprite code of plane0=1, plane1=0 is transparent and outputs the background.
- R7: A sprite code of plane0=1, plane1=1 outputs the background XOR 0xFF.
- R8: Sprite pixel (row r, column c) takes its plane0 bit from byte address r*16 + c/8 and its plane1 bit from byte address r*16 + 8 + c/8, at bit 7 - (c mod 8). The most significant bit is the leftmost pixel.
- R9: The sprite pixel at (`hotX`, `hotY`) lands on logical position (`curX`, `curY`). Sprite column = logical x - `curX` + `hotX`, and the row follows the same rule with y.
- R10: Logical position = physical pixel position + panning offset (`panX`, `panY`), so the cursor follows the logical screen as panning changes.
- R11: Pixels whose computed sprite column or row lies outside 0..63 show the background. Sprite parts pushed past the top or left edge are clipped and never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sprWe | input | 1 | Sprite image byte write strobe |
| sprAddr | input | 10 | Sprite image byte address |
| sprData | input | 8 | Sprite image byte data |
| colorOne | input | PIX_W | Colour for code plane0=0/plane1=1 |
| colorTwo | input | PIX_W | Colour for code plane0=0/plane1=0 |
| hotX | input | 6 | Hot-spot column inside the sprite |
| hotY | input | 6 | Hot-spot row inside the sprite |
| curX | input | COORD_W | Cursor x on the logical screen |
| curY | input | COORD_W | Cursor y on the logical screen |
| panX | input | COORD_W | Horizontal panning offset |
| panY | input | COORD_W | Vertical panning offset |
| curEn | input | 1 | Cursor enable |
| pixX | input | COORD_W | Physical x of the current pixel |
| pixY | input | COORD_W | Physical y of the current pixel |
| bgIn | input | PIX_W | Background pixel value |
| pixOut | output | PIX_W | Composited pixel, one cycle later |

## Verification
The bench uses the default widths: PIX_W=8 and COORD_W=12. The 12-bit coordinates let it place the cursor at 200,200 for a directed layout probe and at 3,2 with a large hot-spot to test top/left clipping. A panned window then moves the cursor across the physical screen. A behavioural model computes the sprite column and row from signed integer arithmetic and indexes its own byte array, and it is compared with the output on every clock, so every code value is met over about a thousand loaded bytes.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  localparam int SPR_DIM     = 64;                        // sprite side, power of two
  localparam int SPR_PLANES  = 2;
  localparam int SPR_BYTES   = SPR_DIM * SPR_DIM * SPR_PLANES / 8;
  localparam int SPR_IDX_W   = $clog2(SPR_DIM);
  localparam int SPR_ADDR_W  = $clog2(SPR_BYTES);
  localparam int COL_BYTE_W  = SPR_IDX_W - 3;

  typedef enum logic [1:0] {
    CODE_COL2   = 2'b00,
    CODE_COL1   = 2'b01,
    CODE_CLEAR  = 2'b10,
    CODE_INVERT = 2'b11
  } sprCode_t;

  typedef struct packed {
    logic                  inWin;
    logic [SPR_IDX_W-1:0]  row;
    logic [SPR_IDX_W-1:0]  col;
    logic                  memWe;
    logic [SPR_ADDR_W-1:0] memAddr;
    logic [7:0]            memData;
  } ctrlStrobe_t;
endpackage

// File: rtl/cursor_ctrl.sv
module cursor_ctrl
  import cursor_pkg::*;
#(
  parameter int COORD_W = 12
) (
  input  logic                  sprWe,
  input  logic [SPR_ADDR_W-1:0] sprAddr,
  input  logic [7:0]            sprData,
  input  logic [SPR_IDX_W-1:0]  hotX,
  input  logic [SPR_IDX_W-1:0]  hotY,
  input  logic [COORD_W-1:0]    curX,
  input  logic [COORD_W-1:0]    curY,
  input  logic [COORD_W-1:0]    panX,
  input  logic [COORD_W-1:0]    panY,
  input  logic                  curEn,
  input  logic [COORD_W-1:0]    pixX,
  input  logic [COORD_W-1:0]    pixY,
  output ctrlStrobe_t           strb
);
  // Signed offset of a screen pixel inside the sprite; three extra bits
  // keep the sum of four coordinates free of overflow.
  localparam int GW = COORD_W + 3;

  function automatic logic signed [GW-1:0] spriteOffs(
    input logic [COORD_W-1:0]   p,
    input logic [COORD_W-1:0]   pan,
    input logic [COORD_W-1:0]   cur,
    input logic [SPR_IDX_W-1:0] hot
  );
    spriteOffs = $signed({3'b000, p}) + $signed({3'b000, pan})
               - $signed({3'b000, cur})
               + $signed({{(GW-SPR_IDX_W){1'b0}}, hot});
  endfunction

  logic signed [GW-1:0] offsX, offsY;
  logic                 hitX, hitY;

  always_comb begin
    offsX = spriteOffs(pixX, panX, curX, hotX);
    offsY = spriteOffs(pixY, panY, curY, hotY);
    // 0 <= offs < SPR_DIM: all bits above the index are zero (sign included)
    hitX  = (offsX[GW-1:SPR_IDX_W] == '0);
    hitY  = (offsY[GW-1:SPR_IDX_W] == '0);
  end

  always_comb begin
    strb.inWin   = curEn && hitX && hitY;
    strb.row     = offsY[SPR_IDX_W-1:0];
    strb.col     = offsX[SPR_IDX_W-1:0];
    strb.memWe   = sprWe;
    strb.memAddr = sprAddr;
    strb.memData = sprData;
  end
endmodule

// File: rtl/cursor_datapath.sv
module cursor_datapath
  import cursor_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strb,
  input  logic [PIX_W-1:0] colorOne,
  input  logic [PIX_W-1:0] colorTwo,
  input  logic [PIX_W-1:0] bgIn,
  output logic [PIX_W-1:0] pixOut
);
  logic [7:0] spriteMem [SPR_BYTES];

  always_ff @(posedge clk) begin
    if (strb.memWe) spriteMem[strb.memAddr] <= strb.memData;
  end

  // Per row: plane0 bytes first, then plane1 bytes; MSB is the leftmost pixel.
  logic [SPR_PLANES-1:0] planeBit;
  logic [2:0]            bitSel;
  assign bitSel = ~strb.col[2:0];

  for (genvar p = 0; p < SPR_PLANES; p++) begin : g_plane
    logic [SPR_ADDR_W-1:0] planeAddr;
    logic [7:0]            planeByte;
    assign planeAddr   = {strb.row, 1'(p), strb.col[SPR_IDX_W-1:3]};
    assign planeByte   = spriteMem[planeAddr];
    assign planeBit[p] = planeByte[bitSel];
  end

  sprCode_t         code;
  logic [PIX_W-1:0] nextPix;

  always_comb begin
    code    = sprCode_t'({planeBit[0], planeBit[1]});
    nextPix = bgIn;
    if (strb.inWin) begin
      unique case (code)
        CODE_COL2:   nextPix = colorTwo;
        CODE_COL1:   nextPix = colorOne;
        CODE_CLEAR:  nextPix = bgIn;
        CODE_INVERT: nextPix = ~bgIn;
        default:     nextPix = bgIn;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pixOut <= '0;
    else       pixOut <= nextPix;
  end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int COORD_W = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sprWe,
  input  logic [SPR_ADDR_W-1:0] sprAddr,
  input  logic [7:0]            sprData,
  input  logic [PIX_W-1:0]      colorOne,
  input  logic [PIX_W-1:0]      colorTwo,
  input  logic [SPR_IDX_W-1:0]  hotX,
  input  logic [SPR_IDX_W-1:0]  hotY,
  input  logic [COORD_W-1:0]    curX,
  input  logic [COORD_W-1:0]    curY,
  input  logic [COORD_W-1:0]    panX,
  input  logic [COORD_W-1:0]    panY,
  input  logic                  curEn,
  input  logic [COORD_W-1:0]    pixX,
  input  logic [COORD_W-1:0]    pixY,
  input  logic [PIX_W-1:0]      bgIn,
  output logic [PIX_W-1:0]      pixOut
);
  ctrlStrobe_t strb;

  cursor_ctrl #(.COORD_W(COORD_W)) u_ctrl (
    .sprWe(sprWe), .sprAddr(sprAddr), .sprData(sprData),
    .hotX(hotX), .hotY(hotY), .curX(curX), .curY(curY),
    .panX(panX), .panY(panY), .curEn(curEn),
    .pixX(pixX), .pixY(pixY), .strb(strb)
  );

  cursor_datapath #(.PIX_W(PIX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .colorOne(colorOne), .colorTwo(colorTwo),
    .bgIn(bgIn), .pixOut(pixOut)
  );
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk
  import cursor_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int COORD_W = 12
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sprWe,
  input logic [SPR_ADDR_W-1:0] sprAddr,
  input logic [7:0]            sprData,
  input logic [PIX_W-1:0]      colorOne,
  input logic [PIX_W-1:0]      colorTwo,
  input logic [SPR_IDX_W-1:0]  hotX,
  input logic [SPR_IDX_W-1:0]  hotY,
  input logic [COORD_W-1:0]    curX,
  input logic [COORD_W-1:0]    curY,
  input logic [COORD_W-1:0]    panX,
  input logic [COORD_W-1:0]    panY,
  input logic                  curEn,
  input logic [COORD_W-1:0]    pixX,
  input logic [COORD_W-1:0]    pixY,
  input logic [PIX_W-1:0]      bgIn,
  input logic [PIX_W-1:0]      pixOut
);
  // R1
  reset_zero_chk: assert property (@(posedge clk)
    !rstN |-> pixOut == '0);

  // R2
  disabled_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && !$past(curEn) |-> pixOut == $past(bgIn));

  // R7
  output_choice_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (pixOut == $past(bgIn)) || (pixOut == ~$past(bgIn)) ||
                    (pixOut == $past(colorOne)) || (pixOut == $past(colorTwo)));

  // R11
  above_clip_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(int'(pixY) + int'(panY) + SPR_DIM <= int'(curY))
      |-> pixOut == $past(bgIn));

  // R11
  left_clip_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(int'(pixX) + int'(panX) + SPR_DIM <= int'(curX))
      |-> pixOut == $past(bgIn));
endmodule

bind cursor_overlay cursor_overlay_chk #(.PIX_W(PIX_W), .COORD_W(COORD_W)) u_chk (.*);

// File: tb/tb_cursor_overlay.sv
module tb_cursor_overlay;
  localparam int PIX_W   = 8;
  localparam int COORD_W = 12;

  logic               clk = 1'b0;
  logic               rstN;
  logic               sprWe;
  logic [9:0]         sprAddr;
  logic [7:0]         sprData;
  logic [PIX_W-1:0]   colorOne, colorTwo;
  logic [5:0]         hotX, hotY;
  logic [COORD_W-1:0] curX, curY, panX, panY, pixX, pixY;
  logic               curEn;
  logic [PIX_W-1:0]   bgIn;
  logic [PIX_W-1:0]   pixOut;

  int checks = 0;
  int fails  = 0;
  logic [7:0] modelMem [1024];

  always #10 clk = ~clk;

  cursor_overlay #(.PIX_W(PIX_W), .COORD_W(COORD_W)) dut (.*);

  task automatic check(input string tag, input logic [PIX_W-1:0] act, input logic [PIX_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: pixOut=%02h expected=%02h (x=%0d y=%0d)", tag, act, exp, pixX, pixY);
    end
  endtask

  // Behavioural expectation for the inputs currently driven.
  function automatic logic [PIX_W-1:0] refPixel(input string baseTag, output string tag);
    int dx, dy, b0, b1, sh, p0, p1;
    tag = baseTag;
    dx = int'(pixX) + int'(panX) - int'(curX) + int'(hotX);
    dy = int'(pixY) + int'(panY) - int'(curY) + int'(hotY);
    if (!curEn || dx < 0 || dx >= 64 || dy < 0 || dy >= 64) return bgIn;
    b0 = int'(modelMem[dy * 16 + dx / 8]);
    b1 = int'(modelMem[dy * 16 + 8 + dx / 8]);
    sh = 7 - (dx % 8);
    p0 = (b0 >> sh) & 1;
    p1 = (b1 >> sh) & 1;
    if (p0 == 0 && p1 == 0) begin tag = "R4"; return colorTwo; end
    if (p0 == 0 && p1 == 1) begin tag = "R5"; return colorOne; end
    if (p0 == 1 && p1 == 0) begin tag = "R6"; return bgIn; end
    tag = "R7";
    return ~bgIn;
  endfunction

  // Inputs are already driven (at a falling edge); compare after the next rise.
  task automatic tick(input string baseTag);
    logic [PIX_W-1:0] e;
    string t;
    e = refPixel(baseTag, t);
    if (sprWe) modelMem[sprAddr] = sprData;
    @(negedge clk);
    sprWe = 1'b0;
    check(t, pixOut, e);
  endtask

  task automatic scan(input int x0, input int x1, input int y0, input int y1, input string tag);
    for (int y = y0; y <= y1; y++) begin
      for (int x = x0; x <= x1; x++) begin
        pixX = COORD_W'(x);
        pixY = COORD_W'(y);
        bgIn = PIX_W'(x * 7 + y * 13);
        tick(tag);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; sprWe = 1'b0; sprAddr = '0; sprData = '0;
    colorOne = 8'hC3; colorTwo = 8'h3C; hotX = '0; hotY = '0;
    curX = '0; curY = '0; panX = '0; panY = '0; curEn = 1'b0;
    pixX = '0; pixY = '0; bgIn = 8'hA5;
    for (int i = 0; i < 1024; i++) modelMem[i] = 8'h00;
    repeat (3) begin
      @(negedge clk);
      check("R1", pixOut, '0);
    end
    rstN = 1'b1;

    // Load the sprite while the cursor is off: stream passes through (R2).
    for (int a = 0; a < 1024; a++) begin
      sprWe   = 1'b1;
      sprAddr = 10'(a);
      sprData = 8'(a * 73 + (a >> 4) * 29 + 5);
      pixX    = COORD_W'(a);
      pixY    = COORD_W'(a >> 3);
      bgIn    = 8'(a * 11);
      tick("R2");
    end

    // R3: one-cycle latency on a lone value.
    bgIn = 8'h5A; tick("R3");
    check("R3", pixOut, 8'h5A);
    bgIn = 8'h11; tick("R3");
    check("R3", pixOut, 8'h11);

    // R9: hot-spot placement, no panning.
    curEn = 1'b1; curX = 12'd100; curY = 12'd50; hotX = 6'd5; hotY = 6'd7;
    scan(90, 170, 40, 120, "R9");

    // R10: panning shifts the cursor on the physical screen.
    panX = 12'd30; panY = 12'd20;
    scan(60, 140, 20, 100, "R10");

    // R11: large hot-spot near the origin clips at the top/left edge.
    panX = '0; panY = '0; curX = 12'd3; curY = 12'd2; hotX = 6'd20; hotY = 6'd30;
    scan(0, 70, 0, 40, "R11");
    // R11: bottom-right corner of the screen far from the sprite, no wrap.
    scan(4030, 4095, 4080, 4095, "R11");

    // R8: directed layout probe at row 3, columns 10 and 11.
    hotX = '0; hotY = '0; curX = 12'd200; curY = 12'd200;
    pixX = 12'd0; pixY = 12'd0;
    sprWe = 1'b1; sprAddr = 10'd49; sprData = 8'h00; tick("R8");
    sprWe = 1'b1; sprAddr = 10'd57; sprData = 8'h20; tick("R8");
    pixX = 12'd210; pixY = 12'd203; bgIn = 8'h33; tick("R8");
    check("R8", pixOut, colorOne);
    pixX = 12'd211; tick("R8");
    check("R8", pixOut, colorTwo);

    // R2: sprite under the pixel but cursor disabled.
    curEn = 1'b0;
    scan(200, 263, 200, 210, "R2");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule